// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block detects a runaway program. A binary counter advances on every system clock cycle while the timer is enabled. When the count reaches the end of the period that software chose, the block signals an overflow. Six power-of-two periods are available, and a mode register picks one of them. Software keeps the timer from expiring by writing a fixed clear code to a control address before the period runs out.

In normal mode an overflow raises a one-cycle non-maskable interrupt pulse. It also drives an active-low watchdog output to 0 and sets a sticky source flag, which the interrupt handler reads and then clears through a dedicated input. In reset mode an overflow drives a fixed-length reset request instead, and no interrupt is raised. When that request ends, the timer starts again from its cleared state.

The register port is synchronous. A write at address 0 loads the mode byte: bit 7 is the enable, bits 6:4 select the tap and bit 0 selects reset mode. A write at address 1 is checked for the clear code. Reads are combinational.

Top module: `wdt_selectable`

## Requirements
- R1: After power-on reset the mode byte reads 0x80, which means enabled, tap field 0 and reset mode off. In the same state wdt_out_n is 1, and wdt_int, nmi_flag and rst_req are 0.
- R2: With tap field k in the range 0 to 5, the period is P = 2^(TAP_MIN+2k) cycles. With the default parameters that is 2^16 up to 2^26. In normal mode, wdt_int is high for exactly one cycle, P cycles after the clock edge that accepted the last clear code (or after reset is released). Without a clear, it repeats every P cycles.
- R3: Tap field values 6 and 7 give the same period as value 5.
- R4: Writing 0x4E to address 1 zeroes the counter and sets wdt_out_n to 1 on the next edge. If an overflow would happen in the same cycle, the clear wins and no overflow occurs.
- R5: Any other value written to address 1 has no effect on the counter, wdt_out_n, nmi_flag or rst_req.
- R6: wdt_out_n falls to 0 on the same edge as the overflow. It stays 0 until a clear code is accepted or, in reset mode, until the reset request ends.
- R7: nmi_flag is set together with wdt_int and stays set until flag_clr is sampled high. The clear code does not clear it. If a set and a clear happen in the same cycle, the set wins.
- R8: In reset mode (mode bit 0 = 1), an overflow drives rst_req high for exactly RST_LEN cycles (32 by default). It raises neither wdt_int nor nmi_flag. The counter is held at 0 during the request. When the request ends, wdt_out_n returns to 1 and counting restarts, so the next overflow comes P cycles after the request falls.
- R9: With enable (mode bit 7) at 0, the counter holds its value and no overflow occurs. When enable returns to 1, counting resumes from the held value.
- R10: rd_data returns the stored mode byte when rd_addr is 0 and returns 0 when rd_addr is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which also drives the counter |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects mode, 1 selects control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data |
| flag_clr | input | 1 | Write-one-to-clear request for nmi_flag |
| wdt_int | output | 1 | One-cycle non-maskable interrupt pulse |
| nmi_flag | output | 1 | Sticky flag marking the watchdog as the interrupt source |
| wdt_out_n | output | 1 | Active-low watchdog output |
| rst_req | output | 1 | Internal reset request, RST_LEN cycles long |

## Verification
rd_data is combinational and is due in the same cycle as rd_addr. Every other result is registered once and is due at the first rising edge that samples its cause. A clear code lifts wdt_out_n one edge after the write is presented. An overflow shows up on wdt_int, wdt_out_n, nmi_flag or rst_req exactly P edges after the accepting clear edge. rst_req falls RST_LEN edges after it rose. The bench drives inputs 2 ns after a rising edge and advances a behavioural model on each rising edge. It compares every output with that model at the following falling edge, so each result is checked in the exact cycle it is due and never a cycle early or late.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int DATA_W = 8;

   typedef struct packed {
      logic       enable;
      logic [2:0] tap;
      logic [2:0] spare;
      logic       rst_mode;
   } wdt_mode_t;

   localparam logic ADDR_MODE = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;

   localparam wdt_mode_t MODE_POR = '{enable: 1'b1, tap: 3'd0, spare: 3'd0, rst_mode: 1'b0};

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter logic [DATA_W-1:0] CLEAR_CODE = 8'h4E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output wdt_mode_t         mode,
   output logic              clr_hit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= MODE_POR;
      else if (wr_en && wr_addr == ADDR_MODE)
         mode <= wdt_mode_t'(wr_data);
   end

   always_comb begin
      clr_hit = wr_en && (wr_addr == ADDR_CTRL) && (wr_data == CLEAR_CODE);
      rd_data = (rd_addr == ADDR_MODE) ? DATA_W'(mode) : '0;
   end

   // R10: a mode write is visible on the readback port on the next cycle
   assert_mode_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_MODE && rd_addr == ADDR_MODE) |=> rd_data == $past(wr_data));

endmodule

// File: rtl/wdt_tap_counter.sv
module wdt_tap_counter #(
   parameter int CNT_W    = 26,
   parameter int TAP_MIN  = 16,
   parameter int TAP_STEP = 2,
   parameter int NUM_TAPS = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       hold,
   input  logic       clr,
   input  logic [2:0] tap_sel,
   output logic       ovf
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] tap_mask [NUM_TAPS];
   logic [2:0]       sel_idx;

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_mask
      localparam int SH = TAP_MIN + TAP_STEP * g;
      assign tap_mask[g] = ~({CNT_W{1'b1}} << SH);
   end

   always_comb begin
      sel_idx = (int'(tap_sel) >= NUM_TAPS) ? 3'(NUM_TAPS - 1) : tap_sel;
      ovf     = en && !hold && (&(cnt | ~tap_mask[sel_idx]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr || ovf || hold)
         cnt <= '0;
      else if (en)
         cnt <= cnt + CNT_W'(1);
   end

   // R9: a disabled counter keeps its value
   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr && !hold) |=> $stable(cnt));

   // R8: the counter sits at zero during a reset request
   assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> cnt == '0);

endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse #(
   parameter int RST_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int RC_W = (RST_LEN > 2) ? $clog2(RST_LEN) : 1;

   logic [RC_W-1:0] rc;

   assign done = busy && (rc == RC_W'(RST_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         rc   <= '0;
      end else if (start) begin
         busy <= 1'b1;
         rc   <= '0;
      end else if (done) begin
         busy <= 1'b0;
         rc   <= '0;
      end else if (busy) begin
         rc   <= rc + RC_W'(1);
      end
   end

   // R8: the request cannot end before its full length
   assert_pulse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R8: every request starts counting from zero
   assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> rc == '0);

endmodule

// File: rtl/wdt_selectable.sv
module wdt_selectable
   import wdt_pkg::*;
#(
   parameter int                CNT_W      = 26,
   parameter int                TAP_MIN    = 16,
   parameter int                TAP_STEP   = 2,
   parameter int                NUM_TAPS   = 6,
   parameter int                RST_LEN    = 32,
   parameter logic [DATA_W-1:0] CLEAR_CODE = 8'h4E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              flag_clr,
   output logic              wdt_int,
   output logic              nmi_flag,
   output logic              wdt_out_n,
   output logic              rst_req
);

   if (CNT_W != TAP_MIN + TAP_STEP * (NUM_TAPS - 1)) begin : g_bad_width
      $error("CNT_W must equal the longest tap");
   end
   if (NUM_TAPS < 1 || NUM_TAPS > 8) begin : g_bad_taps
      $error("NUM_TAPS must fit the 3-bit tap field");
   end
   if (TAP_MIN < 1 || TAP_STEP < 1) begin : g_bad_tap_min
      $error("TAP_MIN and TAP_STEP must be at least 1");
   end
   if (RST_LEN < 2) begin : g_bad_rst_len
      $error("RST_LEN must be at least 2");
   end

   wdt_mode_t mode;
   logic      clr_hit;
   logic      ovf_raw;
   logic      ovf_evt;
   logic      busy;
   logic      pulse_done;

   wdt_regs #(.CLEAR_CODE(CLEAR_CODE)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .mode    (mode),
      .clr_hit (clr_hit)
   );

   wdt_tap_counter #(
      .CNT_W    (CNT_W),
      .TAP_MIN  (TAP_MIN),
      .TAP_STEP (TAP_STEP),
      .NUM_TAPS (NUM_TAPS)
   ) i_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode.enable),
      .hold    (busy),
      .clr     (clr_hit),
      .tap_sel (mode.tap),
      .ovf     (ovf_raw)
   );

   assign ovf_evt = ovf_raw && !clr_hit;

   wdt_reset_pulse #(.RST_LEN(RST_LEN)) i_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ovf_evt && mode.rst_mode),
      .busy  (busy),
      .done  (pulse_done)
   );

   assign rst_req = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdt_int   <= 1'b0;
         nmi_flag  <= 1'b0;
         wdt_out_n <= 1'b1;
      end else begin
         wdt_int <= ovf_evt && !mode.rst_mode;
         if (ovf_evt && !mode.rst_mode)
            nmi_flag <= 1'b1;
         else if (flag_clr)
            nmi_flag <= 1'b0;
         if (clr_hit)
            wdt_out_n <= 1'b1;
         else if (ovf_evt)
            wdt_out_n <= 1'b0;
         else if (pulse_done)
            wdt_out_n <= 1'b1;
      end
   end

   // R2: the interrupt is a single-cycle pulse
   assert_int_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_int |=> !wdt_int);

   // R6: the output is low whenever the interrupt fires
   assert_out_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_int |-> !wdt_out_n);

   // R4: an accepted clear code releases the output
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_CTRL && wr_data == CLEAR_CODE) |=> wdt_out_n);

   // R7: the flag holds without a clear request
   assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_flag && !flag_clr) |=> nmi_flag);

   // R7: the flag never rises without the interrupt
   assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_flag) |-> wdt_int);

   // R8: no interrupt while a reset request is active
   assert_no_int_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !wdt_int);

endmodule

// File: tb/test_wdt_selectable.sv
module test_wdt_selectable;

   localparam int TMIN  = 4;
   localparam int TSTEP = 2;
   localparam int NT    = 6;
   localparam int CW    = TMIN + TSTEP * (NT - 1);
   localparam int RLEN  = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_addr = 1'b0;
   logic       flag_clr = 1'b0;
   logic [7:0] rd_data;
   logic       wdt_int, nmi_flag, wdt_out_n, rst_req;

   int errors = 0;
   int checks = 0;
   int n_int  = 0;

   always #4 clk = ~clk;

   wdt_selectable #(
      .CNT_W (CW), .TAP_MIN (TMIN), .TAP_STEP (TSTEP), .NUM_TAPS (NT), .RST_LEN (RLEN)
   ) i_wdt_selectable (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_addr (rd_addr), .rd_data (rd_data), .flag_clr (flag_clr), .wdt_int (wdt_int),
      .nmi_flag (nmi_flag), .wdt_out_n (wdt_out_n), .rst_req (rst_req)
   );

   // behavioural reference model
   int       m_cnt, m_rc;
   bit       m_busy, m_int, m_flag, m_out, m_clr, m_ovf, m_done;
   bit [7:0] m_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_rc = 0; m_busy = 0; m_int = 0; m_flag = 0; m_out = 1; m_mode = 8'h80;
      end else begin
         int tsel, per;
         tsel   = (m_mode[6:4] > 5) ? 5 : int'(m_mode[6:4]);
         per    = 1 << (TMIN + TSTEP * tsel);
         m_clr  = wr_en && wr_addr && wr_data == 8'h4E;
         m_ovf  = m_mode[7] && !m_busy && (m_cnt % per == per - 1) && !m_clr;
         m_done = m_busy && m_rc == RLEN - 1;
         m_int  = m_ovf && !m_mode[0];
         if (m_int) m_flag = 1;
         else if (flag_clr) m_flag = 0;
         if (m_clr) m_out = 1;
         else if (m_ovf) m_out = 0;
         else if (m_done) m_out = 1;
         if (m_clr || (m_mode[7] && !m_busy && m_cnt % per == per - 1) || m_busy) m_cnt = 0;
         else if (m_mode[7]) m_cnt = (m_cnt + 1) % (1 << CW);
         if (m_ovf && m_mode[0]) begin m_busy = 1; m_rc = 0; end
         else if (m_done) begin m_busy = 0; m_rc = 0; end
         else if (m_busy) m_rc++;
         if (wr_en && !wr_addr) m_mode = wr_data;
      end
   end

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(wdt_int, m_int, "R2 wdt_int");
         chk(wdt_out_n, m_out, "R6 wdt_out_n");
         chk(nmi_flag, m_flag, "R7 nmi_flag");
         chk(rst_req, m_busy, "R8 rst_req");
         chk(rd_data, rd_addr ? 0 : m_mode, "R10 rd_data");
         if (wdt_int) n_int++;
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_data, 8'h80, "R1 mode after reset");
      chk(wdt_out_n, 1, "R1 out after reset");
      chk(nmi_flag, 0, "R1 flag after reset");
      chk(rst_req, 0, "R1 rst_req after reset");
      rd_addr = 1'b1;
      #1 chk(rd_data, 0, "R10 ctrl readback");
      rd_addr = 1'b0;
      n_int = 0;
      tick(40);
      chk(n_int, 2, "R2 two shortest periods");
      // R5 non-code writes are ignored
      wr(1'b1, 8'h4F);
      wr(1'b1, 8'h00);
      @(negedge clk);
      chk(wdt_out_n, 0, "R5 out still low");
      // R4 clear code
      wr(1'b1, 8'h4E);
      @(negedge clk);
      chk(wdt_out_n, 1, "R4 out released");
      chk(nmi_flag, 1, "R7 flag survives clear code");
      flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
      // flag_clr held across an overflow
      flag_clr = 1'b1; tick(20); flag_clr = 1'b0;
      // R4 clear exactly at the overflow cycle
      wr(1'b1, 8'h4E);
      tick(15);
      wr(1'b1, 8'h4E);
      // keep alive on tap 1
      wr(1'b0, 8'h90);
      wr(1'b1, 8'h4E);
      n_int = 0;
      for (int i = 0; i < 10; i++) begin tick(50); wr(1'b1, 8'h4E); end
      chk(n_int, 0, "R4 serviced timer stays quiet");
      // R9 disable
      wr(1'b0, 8'h10);
      n_int = 0;
      tick(300);
      chk(n_int, 0, "R9 no overflow while disabled");
      wr(1'b0, 8'h90);
      tick(100);
      // tap 2 and tap 5
      wr(1'b0, 8'hA0);
      tick(600);
      wr(1'b0, 8'hD0);
      wr(1'b1, 8'h4E);
      n_int = 0;
      tick(16390);
      chk(n_int, 1, "R2 longest tap");
      // R3 reserved encodings
      wr(1'b0, 8'hE0);
      wr(1'b1, 8'h4E);
      n_int = 0;
      tick(16390);
      chk(n_int, 1, "R3 encoding 6");
      wr(1'b0, 8'hF0);
      wr(1'b1, 8'h4E);
      n_int = 0;
      tick(16390);
      chk(n_int, 1, "R3 encoding 7");
      // R8 reset mode on tap 0
      wr(1'b0, 8'h81);
      wr(1'b1, 8'h4E);
      n_int = 0;
      tick(200);
      chk(n_int, 0, "R8 no interrupt in reset mode");
      wr(1'b0, 8'h80);
      tick(60);
      summary();
   end

endmodule